// File: doc/BRIEF.md
# Interrupt Vector Fetch Unit

This block turns an 8-bit interrupt type number into the start address of its service routine. When a start strobe arrives, it reads the four-byte entry for that type from a table at the bottom of a 20-bit byte-addressed space. The table covers addresses 00000h to 003FFh, so all 256 types fit.

The unit reads the entry one byte at a time over a simple request/ready/valid memory port, so the memory may take any number of cycles to answer. From the four bytes it forms a 16-bit routine offset and a 16-bit segment. It then adds the segment, shifted left by four bit positions, to the offset to give the 20-bit physical address. All three results are registered and announced with a one-cycle done pulse.

The unit is meant to sit between an interrupt controller and the instruction fetch logic of a processor core. A caller starts one fetch, then waits for done. It then takes the offset, segment and physical address, which stay valid until the next fetch completes.

Top module: `ivf_unit`

## Requirements
- R1: A fetch for type T reads exactly four bytes, at addresses 4*T, 4*T+1, 4*T+2 and 4*T+3 in that order. Every one of the 256 types is fetched the same way, and no requested address exceeds 003FFh.
- R2: Each read drives rd_req_o high with rd_addr_o. Both hold unchanged until a rising clock edge at which rd_rdy_i is high. The byte on rd_data_i is then taken at the first later edge at which rd_vld_i is high, and both the ready wait and the valid wait may last any number of cycles.
- R3: offset_o is the word formed from the bytes at 4*T (bits 7:0) and 4*T+1 (bits 15:8).
- R4: segment_o is the word formed from the bytes at 4*T+2 (bits 7:0) and 4*T+3 (bits 15:8).
- R5: target_o equals segment_o*16 + offset_o, kept to its low 20 bits, so that segment FFFFh with offset FFFFh gives 0FFEFh.
- R6: busy_o rises one cycle after an accepted start and falls in the same cycle that done_o rises. rd_req_o is never high while busy_o is low.
- R7: A start strobe seen while busy_o is high is ignored. It neither changes the addresses being read nor starts a second fetch afterwards.
- R8: done_o is high for exactly one cycle. It rises one clock after the edge that takes the fourth byte.
- R9: offset_o, segment_o and target_o change only in the cycle that done_o is high. Between completions they hold their values.
- R10: While rst is high, at the next edge busy_o, rd_req_o and done_o go low and offset_o, segment_o and target_o clear to zero. This holds even in the middle of a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| vec_type_i | input | 8 | Interrupt type number to fetch |
| busy_o | output | 1 | Fetch in progress |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 20 | Memory read byte address |
| rd_rdy_i | input | 1 | Memory accepts the pending request |
| rd_vld_i | input | 1 | Read byte is valid |
| rd_data_i | input | 8 | Read byte |
| done_o | output | 1 | One-cycle completion pulse |
| offset_o | output | 16 | Routine offset from the entry's low word |
| segment_o | output | 16 | Routine segment from the entry's high word |
| target_o | output | 20 | Physical start address of the routine |

## Verification
After a start strobe is sampled, busy_o and the first request appear one edge later. Each later request appears at the edge that takes the previous byte. The bench reacts to every request at a falling edge, stalls for a varying number of cycles before raising ready and again before raising valid, and compares the address it is offered with 4*T plus the byte count.

The results and done_o are due one edge after the fourth valid byte is taken. The bench checks done_o exactly at the falling edge after the fourth valid and reads the outputs there. It then checks one cycle later that done_o has fallen and that the outputs still hold.

All 256 types are swept with expected words and addresses computed arithmetically from a table function. A start during a fetch and a reset during a fetch are each checked at the falling edges that follow them.

// File: rtl/ivf_pkg.sv
package ivf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fetch_state_t;

endpackage

// File: rtl/ivf_seq.sv
module ivf_seq
  import ivf_pkg::*;
#(
  parameter int TYPE_W      = 8,
  parameter int ADDR_W      = 20,
  parameter int ENTRY_BYTES = 4,
  localparam int IDX_W      = $clog2(ENTRY_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [TYPE_W-1:0] vec_type_i,
  input  logic              rd_rdy_i,
  input  logic              rd_vld_i,
  output logic              busy_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              byte_we_o,
  output logic [IDX_W-1:0]  byte_idx_o,
  output logic              finish_o
);

  localparam int PAD_W = ADDR_W - TYPE_W - IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRY_BYTES - 1);

  fetch_state_t state_q;
  logic [IDX_W-1:0] idx_q;
  logic [ADDR_W-1:0] base_addr;
  logic take_byte;

  assign base_addr = {{PAD_W{1'b0}}, vec_type_i, {IDX_W{1'b0}}};
  assign take_byte = (state_q == ST_WAIT) && rd_vld_i;

  assign byte_we_o  = take_byte;
  assign byte_idx_o = idx_q;
  assign finish_o   = take_byte && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      busy_o    <= 1'b0;
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q   <= ST_REQ;
            idx_q     <= '0;
            busy_o    <= 1'b1;
            rd_req_o  <= 1'b1;
            rd_addr_o <= base_addr;
          end
        end
        ST_REQ: begin
          if (rd_rdy_i) begin
            state_q  <= ST_WAIT;
            rd_req_o <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (rd_vld_i) begin
            if (idx_q == LAST_IDX) begin
              state_q <= ST_IDLE;
              busy_o  <= 1'b0;
            end else begin
              state_q   <= ST_REQ;
              idx_q     <= idx_q + 1'b1;
              rd_req_o  <= 1'b1;
              rd_addr_o <= rd_addr_o + 1'b1;
            end
          end
        end
        default: begin
          state_q  <= ST_IDLE;
          busy_o   <= 1'b0;
          rd_req_o <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ivf_assemble.sv
module ivf_assemble #(
  parameter int DATA_W      = 8,
  parameter int WORD_W      = 16,
  parameter int ENTRY_BYTES = 4,
  localparam int IDX_W      = $clog2(ENTRY_BYTES),
  localparam int FLAT_W     = ENTRY_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_we_i,
  input  logic [IDX_W-1:0]  byte_idx_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [WORD_W-1:0] low_word_o,
  output logic [WORD_W-1:0] high_word_o
);

  logic [FLAT_W-1:0] flat_next;

  for (genvar i = 0; i < ENTRY_BYTES; i++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic hit;

    assign hit = byte_we_i && (byte_idx_i == IDX_W'(i));
    assign flat_next[i*DATA_W +: DATA_W] = hit ? byte_i : slot_q;

    always_ff @(posedge clk) begin
      if (rst) slot_q <= '0;
      else if (hit) slot_q <= byte_i;
    end
  end

  assign low_word_o  = flat_next[WORD_W-1:0];
  assign high_word_o = flat_next[2*WORD_W-1:WORD_W];

endmodule

// File: rtl/ivf_target.sv
module ivf_target #(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4,
  localparam int SUM_W    = ADDR_W + 2,
  localparam int PAD_W    = SUM_W - WORD_W
) (
  input  logic [WORD_W-1:0] segment_i,
  input  logic [WORD_W-1:0] offset_i,
  output logic [ADDR_W-1:0] target_o
);

  logic [SUM_W-1:0] seg_ext;
  logic [SUM_W-1:0] off_ext;
  logic [SUM_W-1:0] sum;

  assign seg_ext  = {{PAD_W{1'b0}}, segment_i} << SEG_SHIFT;
  assign off_ext  = {{PAD_W{1'b0}}, offset_i};
  assign sum      = seg_ext + off_ext;
  assign target_o = sum[ADDR_W-1:0];

endmodule

// File: rtl/ivf_unit.sv
module ivf_unit #(
  parameter int TYPE_W    = 8,
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [TYPE_W-1:0] vec_type_i,
  output logic              busy_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_rdy_i,
  input  logic              rd_vld_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              done_o,
  output logic [WORD_W-1:0] offset_o,
  output logic [WORD_W-1:0] segment_o,
  output logic [ADDR_W-1:0] target_o
);

  localparam int ENTRY_BYTES = 2 * WORD_W / DATA_W;
  localparam int IDX_W       = $clog2(ENTRY_BYTES);

  logic             byte_we;
  logic [IDX_W-1:0] byte_idx;
  logic             finish;
  logic [WORD_W-1:0] low_word;
  logic [WORD_W-1:0] high_word;
  logic [ADDR_W-1:0] target_next;

  ivf_seq #(
    .TYPE_W     (TYPE_W),
    .ADDR_W     (ADDR_W),
    .ENTRY_BYTES(ENTRY_BYTES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .vec_type_i(vec_type_i),
    .rd_rdy_i  (rd_rdy_i),
    .rd_vld_i  (rd_vld_i),
    .busy_o    (busy_o),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .byte_we_o (byte_we),
    .byte_idx_o(byte_idx),
    .finish_o  (finish)
  );

  ivf_assemble #(
    .DATA_W     (DATA_W),
    .WORD_W     (WORD_W),
    .ENTRY_BYTES(ENTRY_BYTES)
  ) u_asm (
    .clk        (clk),
    .rst        (rst),
    .byte_we_i  (byte_we),
    .byte_idx_i (byte_idx),
    .byte_i     (rd_data_i),
    .low_word_o (low_word),
    .high_word_o(high_word)
  );

  ivf_target #(
    .WORD_W   (WORD_W),
    .ADDR_W   (ADDR_W),
    .SEG_SHIFT(SEG_SHIFT)
  ) u_tgt (
    .segment_i(high_word),
    .offset_i (low_word),
    .target_o (target_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      offset_o  <= '0;
      segment_o <= '0;
      target_o  <= '0;
    end else begin
      done_o <= finish;
      if (finish) begin
        offset_o  <= low_word;
        segment_o <= high_word;
        target_o  <= target_next;
      end
    end
  end

endmodule

// File: rtl/ivf_unit_chk.sv
module ivf_unit_chk #(
  parameter int ADDR_W    = 20,
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_rdy_i,
  input logic              done_o,
  input logic [WORD_W-1:0] offset_o,
  input logic [WORD_W-1:0] segment_o,
  input logic [ADDR_W-1:0] target_o
);

  localparam logic [ADDR_W-1:0] TABLE_TOP = ADDR_W'(1024);

  logic [ADDR_W+1:0] tgt_ref;
  assign tgt_ref = ({{(ADDR_W+2-WORD_W){1'b0}}, segment_o} << SEG_SHIFT)
                 + {{(ADDR_W+2-WORD_W){1'b0}}, offset_o};

  AST_ADDR_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> (rd_addr_o < TABLE_TOP)); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_rdy_i) |=> (rd_req_o && $stable(rd_addr_o))); // R2

  AST_TARGET_SUM: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (target_o == tgt_ref[ADDR_W-1:0])); // R5

  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> busy_o); // R6

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $fell(busy_o)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> (done_o || ($stable(offset_o) && $stable(segment_o) && $stable(target_o)))); // R9

endmodule

bind ivf_unit ivf_unit_chk #(
  .ADDR_W   (ADDR_W),
  .WORD_W   (WORD_W),
  .SEG_SHIFT(SEG_SHIFT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy_o   (busy_o),
  .rd_req_o (rd_req_o),
  .rd_addr_o(rd_addr_o),
  .rd_rdy_i (rd_rdy_i),
  .done_o   (done_o),
  .offset_o (offset_o),
  .segment_o(segment_o),
  .target_o (target_o)
);

// File: tb/tb_ivf_unit.sv
`timescale 1ns/1ps
module tb_ivf_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [7:0]  vec_type_i = '0;
  logic        busy_o, rd_req_o, done_o;
  logic [19:0] rd_addr_o, target_o;
  logic        rd_rdy_i = 1'b0;
  logic        rd_vld_i = 1'b0;
  logic [7:0]  rd_data_i = '0;
  logic [15:0] offset_o, segment_o;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_base = 0;
  int byte_k = 0;
  int beat_cnt = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ivf_unit dut (
    .clk(clk), .rst(rst), .start_i(start_i), .vec_type_i(vec_type_i),
    .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_rdy_i(rd_rdy_i), .rd_vld_i(rd_vld_i), .rd_data_i(rd_data_i),
    .done_o(done_o), .offset_o(offset_o), .segment_o(segment_o),
    .target_o(target_o)
  );

  function automatic logic [7:0] mem_byte(input int a);
    if (a == 3) return 8'h30;
    if (a < 3) return 8'h00;
    if (a >= 'h3FC) return 8'hFF;
    return 8'((a * 29) + (a >> 3) + 'h5A);
  endfunction

  function automatic int exp_off(input int t);
    return int'({mem_byte(4*t+1), mem_byte(4*t)});
  endfunction

  function automatic int exp_seg(input int t);
    return int'({mem_byte(4*t+3), mem_byte(4*t+2)});
  endfunction

  function automatic int exp_tgt(input int t);
    return ((exp_seg(t) << 4) + exp_off(t)) & 'hFFFFF;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // memory responder with varying ready and valid delays
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req_o && !rst) begin
        int a;
        repeat (beat_cnt % 3) @(negedge clk);
        a = int'(rd_addr_o);
        chk(a == exp_base + byte_k, "R1", a, exp_base + byte_k); // R1 address order
        chk(rd_req_o == 1'b1, "R2", int'(rd_req_o), 1);          // R2 request held
        rd_rdy_i = 1'b1;
        @(negedge clk);
        rd_rdy_i = 1'b0;
        repeat ((beat_cnt * 7) % 4) @(negedge clk);
        rd_vld_i = 1'b1;
        rd_data_i = mem_byte(a);
        chk(done_o == 1'b0, "R8", int'(done_o), 0);
        @(negedge clk);
        rd_vld_i = 1'b0;
        rd_data_i = 8'hxx;
        if (byte_k == 3) chk(done_o == 1'b1, "R8", int'(done_o), 1); // R8 one clock after last byte
        byte_k++;
        beat_cnt++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        finish_run();
      end
    end
  end

  task automatic issue(input int t);
    @(negedge clk);
    exp_base = 4 * t;
    byte_k = 0;
    start_i = 1'b1;
    vec_type_i = 8'(t);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R6", int'(busy_o), 1);
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      if (done_o) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, "R8", int'(seen), 1);
  endtask

  task automatic check_result(input int t);
    chk(int'(offset_o) == exp_off(t), "R3", int'(offset_o), exp_off(t));
    chk(int'(segment_o) == exp_seg(t), "R4", int'(segment_o), exp_seg(t));
    chk(int'(target_o) == exp_tgt(t), "R5", int'(target_o), exp_tgt(t));
    chk(busy_o == 1'b0, "R6", int'(busy_o), 0);
  endtask

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy_o == 0 && rd_req_o == 0 && done_o == 0, "R10", int'({busy_o, rd_req_o, done_o}), 0);
    chk(offset_o == 0 && segment_o == 0 && target_o == 0, "R10", int'(target_o), 0);
    rst = 1'b0;

    // R1 R3 R4 R5 sweep of every type
    for (int t = 0; t < 256; t++) begin
      issue(t);
      wait_done(seen);
      check_result(t);
      @(negedge clk);
      chk(done_o == 1'b0, "R8", int'(done_o), 0);
      chk(int'(target_o) == exp_tgt(t), "R9", int'(target_o), exp_tgt(t));
    end

    // explicit corners: R5 example and wrap
    chk(exp_tgt(0) == 'h30000, "R5", exp_tgt(0), 'h30000);
    chk(exp_tgt(255) == 'h0FFEF, "R5", exp_tgt(255), 'h0FFEF);

    // R9 outputs hold into the next fetch until it completes
    issue(17);
    repeat (3) @(negedge clk);
    chk(int'(target_o) == exp_tgt(255), "R9", int'(target_o), exp_tgt(255));
    wait_done(seen);
    check_result(17);

    // R7 start while busy is ignored
    issue(200);
    repeat (2) @(negedge clk);
    start_i = 1'b1;
    vec_type_i = 8'd9;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(seen);
    chk(int'(offset_o) == exp_off(200), "R7", int'(offset_o), exp_off(200));
    chk(int'(segment_o) == exp_seg(200), "R7", int'(segment_o), exp_seg(200));
    repeat (6) @(negedge clk);
    chk(busy_o == 1'b0 && rd_req_o == 1'b0, "R7", int'({busy_o, rd_req_o}), 0);

    // R10 reset in the middle of a fetch
    issue(77);
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy_o == 0 && rd_req_o == 0 && done_o == 0, "R10", int'({busy_o, rd_req_o, done_o}), 0);
    chk(offset_o == 0 && segment_o == 0 && target_o == 0, "R10", int'(offset_o), 0);
    repeat (20) @(negedge clk);

    // recovery after reset
    issue(3);
    wait_done(seen);
    check_result(3);

    finish_run();
  end

endmodule